// File: doc/BRIEF.md
# Line Checksum and Cross-Chip Parity Recovery Unit

This unit sits between a memory controller and a bank of eight data chips plus one parity chip. Each cache line lives whole inside one data chip, next to an 8-bit checksum. The parity chip holds, at every offset, the XOR of the eight data chips' lines and checksums at that offset. The unit keeps that invariant on every write. On every read it uses the checksum to find errors and the parity to repair them.

A write is a read-modify-write. The unit reads the old line and the old parity, stores the new line with its fresh checksum, and then stores the updated parity. A read fetches the line and tests its checksum. If the checksum fails, the unit reads the same offset from the seven other data chips and from the parity chip. It XORs them into a rebuilt line and checksum, then tests the rebuilt result again. Because the rebuild never touches the owning chip, any damage to that chip can be repaired, including the loss of the whole chip.

The memory side is a single port with a read latency of one cycle. The controller side accepts one request at a time.

Top module: `ckp_line_guard`

## Requirements
- R1: In the cycle after reset is released, `req_ready` is 1 and both `rsp_valid` and `mem_en` are 0.
- R2: The request address splits into a chip number and a line offset. The upper 3 bits select data chip 0..7 and the lower 4 bits give the offset. A write stores the new line in the selected chip with a checksum equal to the XOR of the line's 64 bytes; byte i is bits [8i+7:8i].
- R3: After a write, the parity chip (select value 8) at that offset equals the XOR of the eight data chips at that offset, over both the line and the checksum. The new parity is formed as old parity XOR old line XOR new line. A write answers with a one-cycle `rsp_valid`, with `rsp_ok` low, 5 clock edges after the edge that accepted it.
- R4: A read whose stored checksum matches returns the stored line with `rsp_ok` high and `rsp_fixed` low, 3 edges after acceptance. It does not need the parity chip.
- R5: A checksum mismatch starts a rebuild. The rebuild XORs the parity chip with the same-offset entries of the other seven data chips and never reads the owning chip. It repairs corruption in the line bits and in the stored checksum alike.
- R6: A read whose rebuilt line passes the checksum returns the rebuilt line with `rsp_ok` and `rsp_fixed` high for exactly one cycle, 13 edges after acceptance.
- R7: A read whose rebuilt line still fails the checksum answers 13 edges after acceptance with `rsp_fail` high, `rsp_ok` low and `rsp_rdata` all zero.
- R8: If any single data chip returns garbage for every one of its reads, every line it owns still reads back with its originally written value.
- R9: While a request is in progress, `req_ready` is low and `req_valid` has no effect. A request offered during that time neither writes memory nor produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | {chip[2:0], offset[3:0]} |
| req_wdata | input | 512 | Line to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Read data on `rsp_rdata` is valid |
| rsp_fixed | output | 1 | Read data came from a rebuild |
| rsp_fail | output | 1 | Read could not be repaired |
| rsp_rdata | output | 512 | Read line; zero unless `rsp_ok` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = store, 0 = fetch |
| mem_sel | output | 4 | Chip select; 0..7 data, 8 parity |
| mem_off | output | 4 | Line offset within the chip |
| mem_wline | output | 512 | Line to store |
| mem_wsum | output | 8 | Checksum to store |
| mem_rline | input | 512 | Fetched line, valid one cycle after the fetch |
| mem_rsum | input | 8 | Fetched checksum, valid one cycle after the fetch |

## Verification
The hardest situations to reach from the ports are a whole failed chip and a second failed chip, because a working array never returns bad data. The bench's memory model therefore has a per-chip switch that XORs a fixed pattern into every fetch from that chip. The pattern's bytes XOR to 0x01, and the stored checksum is disturbed by 0x3C, so the damage always shows up as a mismatch. The bench also flips single stored bits in a line or a checksum. A further test holds a conflicting write request on the request port for the whole length of a clean read and of a rebuild, to show that it is dropped.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
    localparam int LINE_BYTES = 64;
    localparam int DATA_CHIPS = 8;
    localparam int OFS_W      = 4;
    localparam int SUM_W      = 8;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int CHIP_W     = $clog2(DATA_CHIPS);
    localparam int SEL_W      = CHIP_W + 1;
    localparam int ADDR_W     = CHIP_W + OFS_W;
    localparam logic [SEL_W-1:0] PAR_SEL = SEL_W'(DATA_CHIPS);

    typedef struct packed {
        logic [LINE_BITS-1:0] data;
        logic [SUM_W-1:0]     sum;
    } line_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_W_OLD, ST_W_PAR, ST_W_DAT, ST_W_PUT,
        ST_R_GET, ST_R_CHK, ST_SCAN, ST_DRAIN
    } state_t;
endpackage

// File: rtl/ckp_sum.sv
module ckp_sum
    import ckp_pkg::*;
(
    input  logic [LINE_BITS-1:0] din,
    output logic [SUM_W-1:0]     sum
);
    always_comb begin
        sum = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            sum = sum ^ din[i*8 +: 8];
        end
    end
endmodule

// File: rtl/ckp_fold.sv
module ckp_fold
    import ckp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  take,
    input  line_t din,
    output line_t acc_nxt
);
    line_t acc;

    assign acc_nxt = take ? (acc ^ din) : acc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else begin
            acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/ckp_line_guard.sv
module ckp_line_guard
    import ckp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LINE_BITS-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_ok,
    output logic                 rsp_fixed,
    output logic                 rsp_fail,
    output logic [LINE_BITS-1:0] rsp_rdata,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [SEL_W-1:0]     mem_sel,
    output logic [OFS_W-1:0]     mem_off,
    output logic [LINE_BITS-1:0] mem_wline,
    output logic [SUM_W-1:0]     mem_wsum,
    input  logic [LINE_BITS-1:0] mem_rline,
    input  logic [SUM_W-1:0]     mem_rsum
);
    state_t               state;
    logic [CHIP_W-1:0]    own_q;
    logic [OFS_W-1:0]     off_q;
    logic [LINE_BITS-1:0] wbuf;
    line_t                old_q;
    line_t                par_q;
    logic [SEL_W-1:0]     idx;
    logic                 pend;
    logic [SEL_W-1:0]     own_sel;
    line_t                rd_line;
    line_t                rb_line;
    logic [SUM_W-1:0]     wr_sum;
    logic [SUM_W-1:0]     rd_sum;
    logic [SUM_W-1:0]     rb_sum;

    assign own_sel      = {1'b0, own_q};
    assign rd_line.data = mem_rline;
    assign rd_line.sum  = mem_rsum;
    assign req_ready    = (state == ST_IDLE);

    ckp_sum u_sum_wr (.din(wbuf),         .sum(wr_sum));
    ckp_sum u_sum_rd (.din(mem_rline),    .sum(rd_sum));
    ckp_sum u_sum_rb (.din(rb_line.data), .sum(rb_sum));

    ckp_fold u_fold (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == ST_R_CHK),
        .take    (pend),
        .din     (rd_line),
        .acc_nxt (rb_line)
    );

    // memory port: one access per cycle, fetch data returns next cycle
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_sel   = '0;
        mem_off   = off_q;
        mem_wline = '0;
        mem_wsum  = '0;
        unique case (state)
            ST_W_OLD: begin mem_en = 1'b1; mem_sel = own_sel; end
            ST_W_PAR: begin mem_en = 1'b1; mem_sel = PAR_SEL; end
            ST_W_DAT: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_sel = own_sel;
                mem_wline = wbuf; mem_wsum = wr_sum;
            end
            ST_W_PUT: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_sel = PAR_SEL;
                mem_wline = par_q.data; mem_wsum = par_q.sum;
            end
            ST_R_GET: begin mem_en = 1'b1; mem_sel = own_sel; end
            ST_SCAN:  begin mem_en = (idx != own_sel); mem_sel = idx; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            own_q     <= '0;
            off_q     <= '0;
            wbuf      <= '0;
            old_q     <= '0;
            par_q     <= '0;
            idx       <= '0;
            pend      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_fixed <= 1'b0;
            rsp_fail  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_fixed <= 1'b0;
            rsp_fail  <= 1'b0;
            rsp_rdata <= '0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    own_q <= req_addr[ADDR_W-1 -: CHIP_W];
                    off_q <= req_addr[OFS_W-1:0];
                    wbuf  <= req_wdata;
                    state <= req_write ? ST_W_OLD : ST_R_GET;
                end
                ST_W_OLD: state <= ST_W_PAR;
                ST_W_PAR: begin
                    old_q <= rd_line;
                    state <= ST_W_DAT;
                end
                ST_W_DAT: begin
                    par_q.data <= rd_line.data ^ old_q.data ^ wbuf;
                    par_q.sum  <= rd_line.sum ^ old_q.sum ^ wr_sum;
                    state      <= ST_W_PUT;
                end
                ST_W_PUT: begin
                    rsp_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                ST_R_GET: state <= ST_R_CHK;
                ST_R_CHK: begin
                    if (rd_sum == mem_rsum) begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        rsp_rdata <= mem_rline;
                        state     <= ST_IDLE;
                    end else begin
                        idx   <= '0;
                        pend  <= 1'b0;
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    pend <= (idx != own_sel);
                    idx  <= idx + SEL_W'(1);
                    if (idx == PAR_SEL) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    pend      <= 1'b0;
                    rsp_valid <= 1'b1;
                    if (rb_sum == rb_line.sum) begin
                        rsp_ok    <= 1'b1;
                        rsp_fixed <= 1'b1;
                        rsp_rdata <= rb_line.data;
                    end else begin
                        rsp_fail  <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: a line store is always followed by the parity store
    a_r3_write_pair: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && mem_sel != PAR_SEL) |=> (mem_en && mem_we && mem_sel == PAR_SEL));

    // R4: responses only appear once the unit is free again
    a_r4_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    // R9: an idle unit leaves memory alone
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_en);

    // R6: the corrected flag is a single-cycle pulse with valid data
    a_r6_fixed_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_fixed |=> !rsp_fixed);
    a_r6_fixed_ok: assert property (@(posedge clk) disable iff (rst)
        rsp_fixed |-> (rsp_ok && rsp_valid));

    // R7: a failed read never carries data
    a_r7_fail_no_data: assert property (@(posedge clk) disable iff (rst)
        rsp_fail |-> (!rsp_ok && !rsp_fixed && rsp_rdata == '0));
endmodule

// File: tb/sim_ckp_line_guard.sv
`timescale 1ns/1ps
module sim_ckp_line_guard;
    import ckp_pkg::*;

    localparam int NLINES = 1 << OFS_W;
    localparam int NSLOT  = DATA_CHIPS + 1;
    localparam int EW     = LINE_BITS + SUM_W;
    localparam int LAT_RD = 3;
    localparam int LAT_WR = 5;
    localparam int LAT_RB = 3 + NSLOT + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 req_valid, req_ready, req_write;
    logic [ADDR_W-1:0]    req_addr;
    logic [LINE_BITS-1:0] req_wdata;
    logic                 rsp_valid, rsp_ok, rsp_fixed, rsp_fail;
    logic [LINE_BITS-1:0] rsp_rdata;
    logic                 mem_en, mem_we;
    logic [SEL_W-1:0]     mem_sel;
    logic [OFS_W-1:0]     mem_off;
    logic [LINE_BITS-1:0] mem_wline, mem_rline;
    logic [SUM_W-1:0]     mem_wsum, mem_rsum;

    ckp_line_guard u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fixed(rsp_fixed),
        .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_sel(mem_sel), .mem_off(mem_off),
        .mem_wline(mem_wline), .mem_wsum(mem_wsum),
        .mem_rline(mem_rline), .mem_rsum(mem_rsum)
    );

    // behavioural memory: nine chips, one-cycle fetch, per-chip failure switch
    logic [EW-1:0]        mem  [NSLOT][NLINES];
    logic [LINE_BITS-1:0] gold [DATA_CHIPS][NLINES];
    logic                 dead [NSLOT];
    logic [EW-1:0]        rd_q;

    assign mem_rline = rd_q[EW-1:SUM_W];
    assign mem_rsum  = rd_q[SUM_W-1:0];

    function automatic logic [EW-1:0] fault_pat();
        logic [LINE_BITS-1:0] d;
        for (int i = 0; i < LINE_BYTES; i++) d[i*8 +: 8] = 8'h5A;
        d[7:0] = d[7:0] ^ 8'h01;
        return {d, 8'h3C};
    endfunction

    function automatic logic [EW-1:0] seen(int k, int o);
        return mem[k][o] ^ (dead[k] ? fault_pat() : '0);
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[int'(mem_sel)][int'(mem_off)] <= {mem_wline, mem_wsum};
            else        rd_q <= seen(int'(mem_sel), int'(mem_off));
        end
    end

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic expect_eq(string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SUM_W-1:0] xsum(logic [LINE_BITS-1:0] d);
        logic [SUM_W-1:0] s = '0;
        for (int i = 0; i < LINE_BYTES; i++) s = s ^ d[i*8 +: 8];
        return s;
    endfunction

    function automatic logic [LINE_BITS-1:0] mk_line(int c, int o, int s);
        logic [LINE_BITS-1:0] d;
        for (int i = 0; i < LINE_BYTES; i++) d[i*8 +: 8] = 8'(c*37 + o*11 + i*7 + s*3);
        return d;
    endfunction

    // kind: 0 write, 1 clean read, 2 corrected read, 3 failed read
    task automatic run(bit wr, int c, int o, logic [LINE_BITS-1:0] wd, int lat, int kind,
                       logic [LINE_BITS-1:0] ed, string tag, bit noise, int nc, int no);
        @(negedge clk);
        expect_eq({tag, " ready before request"}, EW'(req_ready), EW'(1'b1));
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {c[CHIP_W-1:0], o[OFS_W-1:0]};
        req_wdata = wd;
        @(posedge clk);
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            if (n == 1) begin
                if (noise) begin
                    req_write = 1'b1;
                    req_addr  = {nc[CHIP_W-1:0], no[OFS_W-1:0]};
                    req_wdata = ~wd;
                end else begin
                    req_valid = 1'b0;
                end
            end
            expect_eq({tag, " rsp_valid cycle"}, EW'(rsp_valid), EW'(n == lat));
            if (n < lat)
                expect_eq({tag, " ready low while busy (R9)"}, EW'(req_ready), EW'(1'b0));
            if (n == lat) begin
                expect_eq({tag, " rsp_ok"},    EW'(rsp_ok),    EW'(kind == 1 || kind == 2));
                expect_eq({tag, " rsp_fixed"}, EW'(rsp_fixed), EW'(kind == 2));
                expect_eq({tag, " rsp_fail"},  EW'(rsp_fail),  EW'(kind == 3));
                expect_eq({tag, " rsp_rdata"}, EW'(rsp_rdata),
                          (kind == 1 || kind == 2) ? EW'(ed) : '0);
                req_valid = 1'b0;
            end
        end
    endtask

    task automatic check_parity(int o, string tag);
        logic [EW-1:0] x = '0;
        for (int k = 0; k < DATA_CHIPS; k++) x = x ^ mem[k][o];
        expect_eq({tag, " R3 parity invariant"}, mem[DATA_CHIPS][o], x);
    endtask

    task automatic do_write(int c, int o, logic [LINE_BITS-1:0] d, string tag);
        run(1'b1, c, o, d, LAT_WR, 0, '0, tag, 1'b0, 0, 0);
        gold[c][o] = d;
        expect_eq({tag, " R2 stored line and checksum"}, mem[c][o], {d, xsum(d)});
        check_parity(o, tag);
    endtask

    task automatic do_read(int c, int o, int kind, string tag, bit noise, int nc, int no);
        run(1'b0, c, o, '0, (kind == 1) ? LAT_RD : LAT_RB, kind, gold[c][o], tag, noise, nc, no);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NSLOT; k++) begin
            dead[k] = 1'b0;
            for (int o = 0; o < NLINES; o++) mem[k][o] = '0;
        end
        for (int k = 0; k < DATA_CHIPS; k++)
            for (int o = 0; o < NLINES; o++) gold[k][o] = '0;
        rd_q = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1 req_ready after reset", EW'(req_ready), EW'(1'b1));
        expect_eq("R1 rsp_valid after reset", EW'(rsp_valid), EW'(1'b0));
        expect_eq("R1 mem_en after reset",    EW'(mem_en),    EW'(1'b0));

        // R2 / R3: fill four offsets of every data chip
        for (int c = 0; c < DATA_CHIPS; c++)
            for (int o = 0; o < 4; o++)
                do_write(c, o, mk_line(c, o, 1), "R3 fill write");

        // R4: clean reads, including with the parity chip broken
        do_read(0, 2, 1, "R4 clean read chip0", 1'b0, 0, 0);
        do_read(5, 1, 1, "R4 clean read chip5", 1'b0, 0, 0);
        do_read(7, 3, 1, "R4 clean read chip7", 1'b0, 0, 0);
        dead[DATA_CHIPS] = 1'b1;
        do_read(4, 1, 1, "R4 clean read, parity chip dead", 1'b0, 0, 0);
        dead[DATA_CHIPS] = 1'b0;

        // R8 / R6: whole-chip failure of each data chip in turn
        for (int c = 0; c < DATA_CHIPS; c++) begin
            dead[c] = 1'b1;
            do_read(c, 3, 2, "R8 whole chip dead", 1'b0, 0, 0);
            do_read(c, 0, 2, "R6 corrected read", 1'b0, 0, 0);
            dead[c] = 1'b0;
        end

        // R5: one stored data bit flipped, then one stored checksum bit flipped
        mem[3][2][SUM_W + 100] = ~mem[3][2][SUM_W + 100];
        do_read(3, 2, 2, "R5 single data bit", 1'b0, 0, 0);
        mem[3][2][SUM_W + 100] = ~mem[3][2][SUM_W + 100];
        mem[6][1][0] = ~mem[6][1][0];
        do_read(6, 1, 2, "R5 checksum bit", 1'b0, 0, 0);
        mem[6][1][0] = ~mem[6][1][0];

        // R7: two data chips dead at once
        dead[2] = 1'b1;
        dead[5] = 1'b1;
        do_read(2, 0, 3, "R7 two chips dead", 1'b0, 0, 0);
        dead[2] = 1'b0;
        dead[5] = 1'b0;

        // R3: overwrite an existing line twice, then read it back
        do_write(1, 0, mk_line(9, 9, 2), "R3 overwrite");
        do_write(1, 0, '1, "R3 overwrite ones");
        do_read(1, 0, 1, "R4 read after overwrite", 1'b0, 0, 0);

        // R9: conflicting write held on the port during a clean read and a rebuild
        do_read(6, 2, 1, "R9 noise clean", 1'b1, 0, 3);
        expect_eq("R9 noise target untouched", mem[0][3], {gold[0][3], xsum(gold[0][3])});
        dead[4] = 1'b1;
        do_read(4, 0, 2, "R9 noise rebuild", 1'b1, 1, 1);
        dead[4] = 1'b0;
        expect_eq("R9 noise target untouched", mem[1][1], {gold[1][1], xsum(gold[1][1])});
        check_parity(1, "R9");
        repeat (3) begin
            @(negedge clk);
            expect_eq("R9 no stray response", EW'(rsp_valid), EW'(1'b0));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule